// File: doc/BRIEF.md
# I2C Register-Map Control Slave

This block is an I2C target that gives a host access to a small bank of 8-bit control registers. The bus lines arrive from pads as raw levels, are brought into the system clock domain through two flip-flops each, and are then searched for clock edges and for START, repeated START and STOP conditions. The 7-bit device address is the fixed pattern `10010` followed by two strap inputs, so up to four of these slaves can share one bus.

After its address, a write carries a pointer byte and then any number of data bytes. The pointer byte selects a register and holds a flag that makes the pointer step after every byte. A read returns the register under the pointer, stepping after each byte the master acknowledges when the flag is set. To read from a new register, the master writes the pointer and then issues a repeated START in read direction. The register contents are also presented in parallel to the rest of the chip.

Top module: `i2c_regmap_slave`

## Requirements
- R1: After reset, register i holds 8'hA0 + i, SDA is released (`sda_oe` = 0), the pointer is index 1 and the step flag is clear.
- R2: An address byte whose upper seven bits equal {1,0,0,1,0,`addr_strap[1]`,`addr_strap[0]`} is acknowledged by pulling SDA low during the ninth clock; bit 0 of that byte selects read (1) or write (0).
- R3: An address byte that does not match leaves SDA released until the next START or STOP, and following bytes change no register.
- R4: In a write, the byte after the address is the pointer byte: bit 7 is the step flag and bits [IDX_W-1:0] (bits [2:0] with 8 registers) give the register index; other bits are ignored. Each data byte is acknowledged and stored in the register under the pointer.
- R5: With the step flag set, each stored data byte advances the pointer by one, wrapping from the last register to register 0.
- R6: With the step flag clear, all data bytes of a write land in the same register.
- R7: A read sends the register under the pointer MSB first; with the step flag set, each master ACK advances the pointer so the next byte is the next register.
- R8: With the step flag clear, every byte of a read repeats the same register.
- R9: A read issued before any pointer byte has been written starts at register 1.
- R10: A master NACK after a read byte ends the transfer: SDA stays released for any further clocks until START or STOP.
- R11: A repeated START restarts address decoding, so a pointer write followed by a repeated START and a read returns data from the new pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| addr_strap | input | 2 | Low two bits of the device address |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_q | output | NUM_REGS*8 | Register contents, register i at bits [8i+7:8i] |

## Verification
The assertions watch the per-cycle rules of the bus engine: a START always sends it back to address decoding, a STOP always parks it, SDA is never driven while the transaction is being ignored, SDA is driven only in acknowledge or read-data states, and the drive only changes right after an SCL fall or a bus condition. Whether the right data lands in the right register, how the pointer steps and wraps, the start-up pointer, address filtering with different straps and the effect of a master NACK can only be shown by the bench's complete transactions, which compare bus reads and the parallel register outputs against a model.

// File: rtl/i2c_regmap_pkg.sv
// Package: shared types and constants of the I2C register-map slave.
// Assumes byte-wide registers and the 7-bit address form 10010xx.
package i2c_regmap_pkg;

    localparam int BYTE_W = 8;
    localparam logic [4:0] DEV_ID_HI = 5'b10010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_MAP,
        ST_MAP_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } slv_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the clock domain through SYNC_STAGES flops each,
// then reports SCL edges and START/STOP conditions one cycle wide.
// Assumes both lines idle high and the system clock oversamples SCL well.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_s;
    logic scl_d;
    logic sda_d;

    // Synchronizer chains, the first stage takes the pad level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe[0] <= scl_in;
            sda_pipe[0] <= sda_in;
        end
    end

    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
            // Further synchronizer stages.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else begin
                    scl_pipe[g] <= scl_pipe[g-1];
                    sda_pipe[g] <= sda_pipe[g-1];
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_regmap_regfile.sv
// Module: i2c_regmap_regfile
// Bank of NUM_REGS byte registers with one write port and one combinational
// read port; register i resets to RST_BASE + i. Out-of-range indices read
// as zero and are not written.
module i2c_regmap_regfile
    import i2c_regmap_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter logic [BYTE_W-1:0] RST_BASE = 8'hA0,
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);

    logic [BYTE_W-1:0] mem [NUM_REGS];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            // One storage register with its own reset value.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[g] <= RST_BASE + BYTE_W'(g);
                end else if (wr_en && (int'(wr_idx) == g)) begin
                    mem[g] <= wr_data;
                end
            end
            assign regs_flat[g*BYTE_W +: BYTE_W] = mem[g];
        end
    endgenerate

    // Read multiplexer with range guard.
    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < NUM_REGS) begin
            rd_data = mem[rd_idx];
        end
    end

endmodule

// File: rtl/i2c_regmap_ctrl.sv
// Module: i2c_regmap_ctrl
// Bus engine: shifts bytes on SCL rises, decodes address and pointer bytes,
// drives ACK and read data after SCL falls, and steps the register pointer.
// Assumes edge/condition pulses from i2c_line_sync; never stretches SCL.
module i2c_regmap_ctrl
    import i2c_regmap_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int DEFAULT_PTR = 1,
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        strap,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe,
    output slv_state_e        state
);

    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic [IDX_W-1:0]  ptr;
    logic              incr;
    logic              is_read;

    // Next pointer value with wrap at the top of the bank.
    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (int'(p) >= NUM_REGS - 1) ? '0 : p + 1'b1;
    endfunction

    assign rd_idx = ptr;

    // Protocol state machine, byte shifting, pointer and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            tx      <= '0;
            ptr     <= IDX_W'(DEFAULT_PTR);
            incr    <= 1'b0;
            is_read <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_MAP, ST_WDATA: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == {DEV_ID_HI, strap}) begin
                                    state   <= ST_ADDR_ACK;
                                    sda_oe  <= 1'b1;
                                    is_read <= shreg[0];
                                    tx      <= rd_data;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (state == ST_MAP) begin
                                state  <= ST_MAP_ACK;
                                sda_oe <= 1'b1;
                                ptr    <= shreg[IDX_W-1:0];
                                incr   <= shreg[7];
                            end else begin
                                state   <= ST_WDATA_ACK;
                                sda_oe  <= 1'b1;
                                wr_en   <= 1'b1;
                                wr_idx  <= ptr;
                                wr_data <= shreg;
                                if (incr) begin
                                    ptr <= bump(ptr);
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (is_read) begin
                                state  <= ST_RDATA;
                                sda_oe <= ~tx[7];
                            end else begin
                                state  <= ST_MAP;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_MAP_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            state  <= ST_WDATA;
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                state   <= ST_RACK;
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                            end else begin
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            if (!sda_s) begin
                                bit_cnt <= 4'd1;
                                if (incr) begin
                                    ptr <= bump(ptr);
                                end
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else if (scl_fall && bit_cnt == 4'd1) begin
                            state   <= ST_RDATA;
                            bit_cnt <= '0;
                            tx      <= rd_data;
                            sda_oe  <= ~rd_data[7];
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_regmap_slave.sv
// Module: i2c_regmap_slave (top)
// I2C target with a pointer-addressed bank of byte registers. Chains the
// line synchronizer, the bus engine and the register bank. SDA is open
// drain: sda_oe = 1 pulls the line low. Assumes NUM_REGS fits the pointer
// field of the pointer byte (at most 128).
module i2c_regmap_slave
    import i2c_regmap_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DEFAULT_PTR = 1,
    parameter logic [7:0] RST_BASE = 8'hA0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_in,
    input  logic                       sda_in,
    input  logic [1:0]                 addr_strap,
    output logic                       sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0] regs_q
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic              scl_rise;
    logic              scl_fall;
    logic              sda_s;
    logic              start_det;
    logic              stop_det;
    logic [IDX_W-1:0]  rd_idx;
    logic [BYTE_W-1:0] rd_data;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    slv_state_e        ctl_state;

    i2c_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_s    (sda_s),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_regmap_ctrl #(
        .NUM_REGS   (NUM_REGS),
        .DEFAULT_PTR(DEFAULT_PTR)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_s    (sda_s),
        .start_det(start_det),
        .stop_det (stop_det),
        .strap    (addr_strap),
        .rd_data  (rd_data),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe),
        .state    (ctl_state)
    );

    i2c_regmap_regfile #(
        .NUM_REGS(NUM_REGS),
        .RST_BASE(RST_BASE)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .regs_flat(regs_q)
    );

endmodule

// File: rtl/i2c_regmap_slave_chk.sv
// Module: i2c_regmap_slave_chk
// Protocol checker bound into the top; observes the engine state, the SDA
// drive and the synchronizer's edge and condition pulses.
module i2c_regmap_slave_chk
    import i2c_regmap_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input slv_state_e ctl_state
);

    // R11: a START always returns the engine to address decoding.
    assert_start_restarts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (ctl_state == ST_ADDR));

    // R1: a STOP always parks the engine with SDA released.
    assert_stop_parks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (ctl_state == ST_IDLE && !sda_oe));

    // R3 and R10: an ignored transaction never drives SDA.
    assert_ignore_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_IGNORE || ctl_state == ST_IDLE) |-> !sda_oe);

    // R2: SDA is driven only in acknowledge or read-data states.
    assert_drive_in_ack_or_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (ctl_state == ST_ADDR_ACK || ctl_state == ST_MAP_ACK ||
                    ctl_state == ST_WDATA_ACK || ctl_state == ST_RDATA));

    // R7: the SDA drive only changes right after an SCL fall or a bus condition.
    assert_drive_changes_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

endmodule

bind i2c_regmap_slave i2c_regmap_slave_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .ctl_state(ctl_state)
);

// File: tb/i2c_regmap_slave_tb_top.sv
// Bench: bus-functional I2C master plus a reference model of the register
// bank and pointer; directed corner cases followed by seeded random traffic.
module i2c_regmap_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 8;
    localparam int Q          = 5;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] strap = 2'b00;
    logic sda_oe;
    logic [NREG*8-1:0] regs_q;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regmap_slave #(.NUM_REGS(NREG)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .addr_strap(strap),
        .sda_oe    (sda_oe),
        .regs_q    (regs_q)
    );

    int n_checks = 0;
    int n_fail = 0;
    int oe_seen = 0;
    bit done = 1'b0;
    logic [7:0] model [NREG];
    int mptr;
    bit mincr;

    // Count cycles in which the slave drives SDA.
    always @(posedge clk) if (sda_oe) oe_seen++;

    function automatic int nxt(input int p);
        return (p + 1) % NREG;
    endfunction

    function automatic logic [7:0] addr_byte(input logic [1:0] s, input bit rd);
        return {5'b10010, s, rd};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            sda_m = 1'b1; wq();
            scl_m = 1'b1; wq();
        end
        sda_m = 1'b0; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        acked = !sda_line;
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wq();
            scl_m = 1'b1; wq();
            b = {b[6:0], sda_line};
            wq();
            scl_m = 1'b0; wq();
        end
        sda_m = ack ? 1'b0 : 1'b1; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++) begin
            chk(regs_q[i*8 +: 8] == model[i], req, $sformatf("reg %0d", i),
                int'(regs_q[i*8 +: 8]), int'(model[i]));
        end
    endtask

    task automatic do_write(input int idx, input bit inc, input int n,
                            input logic [7:0] d [8], input string req);
        bit a;
        logic [7:0] mapb;
        mapb = {inc, 4'b0000, 3'(idx)};
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        chk(a, "R2", "write address ack", int'(a), 1);
        send_byte(mapb, a);
        chk(a, "R4", "pointer byte ack", int'(a), 1);
        mptr = idx; mincr = inc;
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], a);
            chk(a, "R4", "data ack", int'(a), 1);
            model[mptr] = d[k];
            if (mincr) mptr = nxt(mptr);
        end
        bus_stop();
        check_regs(req);
    endtask

    task automatic read_body(input int n, input string req);
        logic [7:0] got;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, got);
            chk(got == model[mptr], req, "read byte", int'(got), int'(model[mptr]));
            if (k != n - 1 && mincr) mptr = nxt(mptr);
        end
        bus_stop();
    endtask

    task automatic do_read_cur(input int n, input string req);
        bit a;
        bus_start();
        send_byte(addr_byte(strap, 1'b1), a);
        chk(a, "R2", "read address ack", int'(a), 1);
        read_body(n, req);
    endtask

    task automatic do_read_map(input logic [7:0] mapb, input int n, input string req);
        bit a;
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        chk(a, "R2", "write address ack", int'(a), 1);
        send_byte(mapb, a);
        chk(a, "R4", "pointer byte ack", int'(a), 1);
        mptr = int'(mapb[2:0]); mincr = mapb[7];
        bus_start();
        send_byte(addr_byte(strap, 1'b1), a);
        chk(a, "R11", "address ack after repeated START", int'(a), 1);
        read_body(n, req);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // Main stimulus sequence.
    initial begin
        logic [7:0] d [8];
        logic [7:0] got;
        bit a;
        int mark;
        void'($urandom(32'd4242));
        for (int i = 0; i < NREG; i++) model[i] = 8'hA0 + 8'(i);
        mptr = 1; mincr = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        check_regs("R1");
        chk(sda_oe == 1'b0, "R1", "sda released after reset", int'(sda_oe), 0);

        // R9 and R8: first read starts at register 1 and repeats it
        do_read_cur(2, "R9");

        // R6: step flag clear keeps all bytes in one register
        d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
        do_write(3, 1'b0, 3, d, "R6");

        // R5: step flag set walks and wraps
        d[0] = 8'h5A; d[1] = 8'h6B; d[2] = 8'h7C; d[3] = 8'h8D;
        do_write(6, 1'b1, 4, d, "R5");

        // R7 and R11: pointer write, repeated START, stepping read across wrap
        do_read_map(8'h86, 4, "R7");

        // R8: read with step flag clear repeats
        do_read_map(8'h03, 3, "R8");

        // R4: ignored upper pointer bits
        d[0] = 8'hC3;
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        send_byte(8'h7A, a);
        send_byte(d[0], a);
        bus_stop();
        model[2] = 8'hC3; mptr = 2; mincr = 1'b0;
        chk(regs_q[2*8 +: 8] == 8'hC3, "R4", "upper pointer bits ignored",
            int'(regs_q[2*8 +: 8]), 8'hC3);

        // R3: mismatched address is ignored
        strap = 2'b10;
        mark = oe_seen;
        bus_start();
        send_byte(addr_byte(2'b01, 1'b0), a);
        chk(!a, "R3", "no ack on wrong address", int'(a), 0);
        send_byte(8'h00, a);
        send_byte(8'hEE, a);
        bus_stop();
        chk(oe_seen == mark, "R3", "sda never driven", oe_seen - mark, 0);
        check_regs("R3");

        // R10: NACK ends the read
        bus_start();
        send_byte(addr_byte(strap, 1'b1), a);
        chk(a, "R2", "read address ack with strap 2", int'(a), 1);
        recv_byte(1'b0, got);
        chk(got == model[mptr], "R10", "byte before NACK", int'(got), int'(model[mptr]));
        mark = oe_seen;
        recv_byte(1'b0, got);
        chk(got == 8'hFF && oe_seen == mark, "R10", "released after NACK",
            int'(got), 8'hFF);
        bus_stop();

        // Random traffic over all straps and operations
        for (int t = 0; t < 36; t++) begin
            int op;
            int n;
            strap = 2'($urandom);
            op = int'($urandom % 3);
            n = 1 + int'($urandom % 4);
            if (op == 0) begin
                for (int k = 0; k < 8; k++) d[k] = 8'($urandom);
                do_write(int'($urandom % NREG), 1'($urandom), n, d, "R5");
            end else if (op == 1) begin
                do_read_cur(n, "R7");
            end else begin
                do_read_map({1'($urandom), 4'($urandom), 3'($urandom)}, n, "R7");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule